// File: doc/BRIEF.md
# Bus Initiator Disconnect Controller

This block lets software detach a subsystem's master port from the main interconnect in an orderly way and attach it again later. Software writes a request bit; from the next cycle the block refuses to grant new transactions and forces every write byte enable to zero. It then waits until the outstanding-transaction count reported by the port logic reaches zero, raises a disconnect request toward the interconnect and waits for the acknowledge.

The block returns to normal operation when the request is withdrawn. Either a reconnect input pulse or a software write to a second control bit can withdraw it. Normal operation resumes only once the interconnect has dropped its acknowledge. Progress is reported as a 2-bit link status on a port and through a read-only status word.

Top module: `initiator_detach_ctrl`

## Requirements
- R1: After reset the link status is 2 (active), the request bit reads 0 and `disc_req_o` is low.
- R2: A write to word address 0 with data bit 0 set, made while the status is 2, moves the status to 1 (attempting) after that clock edge, and the request bit (read data bit 0 at address 0) then reads 1.
- R3: A write to address 0 with data bit 0 clear and data bit 1 clear changes nothing.
- R4: While the status is not 2, `txn_grant_o` is 0 and `wr_be_o` is all zero. While the status is 2, `txn_grant_o` equals `txn_valid_i` and `wr_be_o` equals `wr_be_i`.
- R5: In the attempting state `disc_req_o` stays low while the outstanding count is nonzero. It rises on the edge after a cycle in which the count was zero.
- R6: When `disc_ack_i` is high while `disc_req_o` is high in the attempting state, the status becomes 0 (disconnected) on the next edge and the request bit reads 0.
- R7: In the disconnected state, a `reconnect_i` pulse or a write to address 0 with data bit 1 set drops `disc_req_o` on the next edge. The status stays 0 while `disc_ack_i` is high and becomes 2 on the edge after a cycle in which it is low.
- R8: A reconnect (input or write bit 1) outside the disconnected state is ignored, and a request write while the status is not 2 is ignored.
- R9: A read of word address 1 returns the status in bits 1:0 (0 disconnected, 1 attempting, 2 active). Reads of addresses 2 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (write and read) |
| reg_wdata | input | 2 | Write data: bit 0 request, bit 1 reconnect |
| reg_rdata | output | DATA_W | Read data for `reg_addr` |
| txn_valid_i | input | 1 | Upstream has a transaction to issue |
| txn_grant_o | output | 1 | Transaction may be issued this cycle |
| wr_be_i | input | BE_W | Write byte enables from the initiator |
| wr_be_o | output | BE_W | Byte enables toward the interconnect |
| outstanding_i | input | CNT_W | Count of transactions still in flight |
| disc_req_o | output | 1 | Disconnect request to the interconnect |
| disc_ack_i | input | 1 | Disconnect acknowledge from the interconnect |
| reconnect_i | input | 1 | Pulse that withdraws the disconnect |
| link_status_o | output | 2 | Link status: 0 disconnected, 1 attempting, 2 active |

## Verification
The bench uses the default widths: a 4-lane byte enable, a 4-bit outstanding count and a 2-bit address. With these values every address, including the two unused ones, is read, and the drain can be held off by counts of 3 and 2 before the count reaches zero. The acknowledge is held high across a reconnect so that the wait for the acknowledge to drop is observed. Reset is also applied in the middle of a drain.

// File: rtl/detach_pkg.sv
package detach_pkg;
    typedef enum logic [2:0] {
        ST_ACTIVE  = 3'd0,
        ST_DRAIN   = 3'd1,
        ST_REQ     = 3'd2,
        ST_OFF     = 3'd3,
        ST_RELEASE = 3'd4
    } link_st_e;

    localparam logic [1:0] STAT_OFF    = 2'd0;
    localparam logic [1:0] STAT_TRYING = 2'd1;
    localparam logic [1:0] STAT_ACTIVE = 2'd2;

    function automatic logic [1:0] status_of(link_st_e s);
        case (s)
            ST_ACTIVE:        return STAT_ACTIVE;
            ST_DRAIN, ST_REQ: return STAT_TRYING;
            default:          return STAT_OFF;
        endcase
    endfunction
endpackage

// File: rtl/detach_fsm.sv
module detach_fsm
    import detach_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  logic     release_i,
    input  logic     cnt_zero_i,
    input  logic     ack_i,
    output link_st_e state_o,
    output logic     disc_req_o
);
    typedef struct packed {
        link_st_e st;
        logic     req;
    } fsm_t;

    fsm_t d, q;

    always_comb begin
        d = q;
        case (q.st)
            ST_ACTIVE:  if (start_i) d.st = ST_DRAIN;
            ST_DRAIN:   if (cnt_zero_i) begin
                            d.st  = ST_REQ;
                            d.req = 1'b1;
                        end
            ST_REQ:     if (ack_i) d.st = ST_OFF;
            ST_OFF:     if (release_i) begin
                            d.st  = ST_RELEASE;
                            d.req = 1'b0;
                        end
            ST_RELEASE: if (!ack_i) d.st = ST_ACTIVE;
            default:    begin
                            d.st  = ST_ACTIVE;
                            d.req = 1'b0;
                        end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= ST_ACTIVE;
            q.req <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign state_o    = q.st;
    assign disc_req_o = q.req;
endmodule

// File: rtl/detach_gate.sv
module detach_gate #(
    parameter int BE_W = 4
) (
    input  logic            open_i,
    input  logic            txn_valid_i,
    output logic            txn_grant_o,
    input  logic [BE_W-1:0] be_i,
    output logic [BE_W-1:0] be_o
);
    assign txn_grant_o = txn_valid_i & open_i;

    for (genvar g = 0; g < BE_W; g++) begin : g_lane
        assign be_o[g] = be_i[g] & open_i;
    end
endmodule

// File: rtl/detach_regs.sv
module detach_regs
    import detach_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        wdata_i,
    input  link_st_e          state_i,
    input  logic              reconnect_i,
    output logic              start_o,
    output logic              release_o,
    output logic [DATA_W-1:0] rdata_o
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);

    logic ctrl_wr;
    logic busy;

    assign ctrl_wr   = we_i && (addr_i == A_CTRL);
    assign start_o   = ctrl_wr && wdata_i[0];
    assign release_o = reconnect_i || (ctrl_wr && wdata_i[1]);
    assign busy      = (state_i == ST_DRAIN) || (state_i == ST_REQ);

    always_comb begin
        rdata_o = '0;
        if (addr_i == A_CTRL)      rdata_o[0]   = busy;
        else if (addr_i == A_STAT) rdata_o[1:0] = status_of(state_i);
    end
endmodule

// File: rtl/initiator_detach_ctrl.sv
module initiator_detach_ctrl
    import detach_pkg::*;
#(
    parameter int ADDR_W = 2,
    parameter int DATA_W = 32,
    parameter int BE_W   = 4,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [1:0]        reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              txn_valid_i,
    output logic              txn_grant_o,
    input  logic [BE_W-1:0]   wr_be_i,
    output logic [BE_W-1:0]   wr_be_o,
    input  logic [CNT_W-1:0]  outstanding_i,
    output logic              disc_req_o,
    input  logic              disc_ack_i,
    input  logic              reconnect_i,
    output logic [1:0]        link_status_o
);
    link_st_e st;
    logic     start, rel;

    detach_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
        .state_i(st), .reconnect_i(reconnect_i),
        .start_o(start), .release_o(rel), .rdata_o(reg_rdata)
    );

    detach_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start), .release_i(rel),
        .cnt_zero_i(outstanding_i == '0), .ack_i(disc_ack_i),
        .state_o(st), .disc_req_o(disc_req_o)
    );

    detach_gate #(.BE_W(BE_W)) u_gate (
        .open_i(st == ST_ACTIVE), .txn_valid_i(txn_valid_i),
        .txn_grant_o(txn_grant_o), .be_i(wr_be_i), .be_o(wr_be_o)
    );

    assign link_status_o = status_of(st);
endmodule

// File: rtl/detach_chk.sv
module detach_chk #(
    parameter int BE_W  = 4,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             txn_grant_o,
    input logic [BE_W-1:0]  wr_be_o,
    input logic [CNT_W-1:0] outstanding_i,
    input logic             disc_req_o,
    input logic             disc_ack_i,
    input logic [1:0]       link_status_o
);
    p_grant_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_status_o != 2'd2) |-> !txn_grant_o);

    p_be_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_status_o != 2'd2) |-> (wr_be_o == '0));

    p_req_after_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(disc_req_o) |-> ($past(outstanding_i) == '0));

    p_ack_completes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (disc_req_o && disc_ack_i && link_status_o == 2'd1) |=> (link_status_o == 2'd0));

    p_release_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(disc_req_o) |-> (link_status_o == 2'd0));

    p_ack_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!disc_req_o && disc_ack_i && link_status_o == 2'd0) |=> (link_status_o == 2'd0));

    p_status_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
        link_status_o != 2'd3);
endmodule

bind initiator_detach_ctrl detach_chk #(.BE_W(BE_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .txn_grant_o(txn_grant_o), .wr_be_o(wr_be_o),
    .outstanding_i(outstanding_i), .disc_req_o(disc_req_o),
    .disc_ack_i(disc_ack_i), .link_status_o(link_status_o)
);

// File: tb/initiator_detach_ctrl_tb.sv
module initiator_detach_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [1:0]  reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        txn_valid_i = 1'b1;
    logic        txn_grant_o;
    logic [3:0]  wr_be_i = 4'hF;
    logic [3:0]  wr_be_o;
    logic [3:0]  outstanding_i = '0;
    logic        disc_req_o;
    logic        disc_ack_i = 1'b0;
    logic        reconnect_i = 1'b0;
    logic [1:0]  link_status_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    initiator_detach_ctrl u_dut (.*);

    typedef struct packed {
        logic       we;
        logic [1:0] addr;
        logic [1:0] wd;
        logic [3:0] cnt;
        logic       ack;
        logic       rec;
        logic [1:0] e_st;
        logic       e_gr;
        logic [3:0] e_be;
        logic       e_dr;
        logic [1:0] e_rd;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 2'd1, 2'd0, 4'd3, 1'b0, 1'b0, 2'd2, 1'b1, 4'hF, 1'b0, 2'd2}, // R1 R9 idle
        '{1'b1, 2'd0, 2'd0, 4'd3, 1'b0, 1'b0, 2'd2, 1'b1, 4'hF, 1'b0, 2'd0}, // R3 write 0
        '{1'b0, 2'd2, 2'd0, 4'd3, 1'b0, 1'b1, 2'd2, 1'b1, 4'hF, 1'b0, 2'd0}, // R8 R9 reconnect in active
        '{1'b1, 2'd0, 2'd2, 4'd3, 1'b0, 1'b0, 2'd2, 1'b1, 4'hF, 1'b0, 2'd0}, // R8 sw reconnect in active
        '{1'b1, 2'd0, 2'd1, 4'd3, 1'b0, 1'b0, 2'd1, 1'b0, 4'h0, 1'b0, 2'd1}, // R2 R4 request
        '{1'b0, 2'd3, 2'd0, 4'd2, 1'b0, 1'b0, 2'd1, 1'b0, 4'h0, 1'b0, 2'd0}, // R5 R9 draining
        '{1'b0, 2'd0, 2'd0, 4'd0, 1'b0, 1'b0, 2'd1, 1'b0, 4'h0, 1'b1, 2'd1}, // R5 drained
        '{1'b0, 2'd1, 2'd0, 4'd0, 1'b0, 1'b0, 2'd1, 1'b0, 4'h0, 1'b1, 2'd1}, // R5 waiting ack
        '{1'b0, 2'd0, 2'd0, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 4'h0, 1'b1, 2'd0}, // R6 ack
        '{1'b1, 2'd0, 2'd1, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 4'h0, 1'b1, 2'd0}, // R8 request while off
        '{1'b0, 2'd1, 2'd0, 4'd0, 1'b1, 1'b1, 2'd0, 1'b0, 4'h0, 1'b0, 2'd0}, // R7 reconnect
        '{1'b0, 2'd1, 2'd0, 4'd0, 1'b1, 1'b0, 2'd0, 1'b0, 4'h0, 1'b0, 2'd0}, // R7 ack still high
        '{1'b0, 2'd1, 2'd0, 4'd0, 1'b0, 1'b0, 2'd2, 1'b1, 4'hF, 1'b0, 2'd2}  // R7 ack dropped
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    initial begin
        #200000000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1 reset values
        chk("R1 status", 32'(link_status_o), 32'd2);
        chk("R1 disc_req", 32'(disc_req_o), 32'd0);
        reg_addr = 2'd0; #1;
        chk("R1 request bit", reg_rdata, 32'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            reg_we = TBL[i].we; reg_addr = TBL[i].addr; reg_wdata = TBL[i].wd;
            outstanding_i = TBL[i].cnt; disc_ack_i = TBL[i].ack;
            reconnect_i = TBL[i].rec;
            @(negedge clk);
            chk($sformatf("R2-table status v%0d", i), 32'(link_status_o), 32'(TBL[i].e_st));
            chk($sformatf("R4 grant v%0d", i), 32'(txn_grant_o), 32'(TBL[i].e_gr));
            chk($sformatf("R4 byte enables v%0d", i), 32'(wr_be_o), 32'(TBL[i].e_be));
            chk($sformatf("R5 disc_req v%0d", i), 32'(disc_req_o), 32'(TBL[i].e_dr));
            chk($sformatf("R9 read v%0d", i), reg_rdata, 32'(TBL[i].e_rd));
            reg_we = 1'b0; reconnect_i = 1'b0;
        end

        // R4 grant follows valid when active
        txn_valid_i = 1'b0; wr_be_i = 4'h5; #1;
        chk("R4 grant no valid", 32'(txn_grant_o), 32'd0);
        chk("R4 be passthrough", 32'(wr_be_o), 32'h5);
        txn_valid_i = 1'b1;

        // R7 software reconnect path, then reset mid-drain (R1)
        outstanding_i = 4'd0;
        reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 2'd1;
        @(negedge clk); reg_we = 1'b0;
        @(negedge clk); disc_ack_i = 1'b1;
        @(negedge clk);
        chk("R6 off", 32'(link_status_o), 32'd0);
        reg_we = 1'b1; reg_wdata = 2'd2;
        @(negedge clk); reg_we = 1'b0;
        chk("R7 sw reconnect drops req", 32'(disc_req_o), 32'd0);
        disc_ack_i = 1'b0;
        @(negedge clk);
        chk("R7 sw reconnect active", 32'(link_status_o), 32'd2);

        outstanding_i = 4'd5;
        reg_we = 1'b1; reg_wdata = 2'd1;
        @(negedge clk); reg_we = 1'b0;
        chk("R2 drain again", 32'(link_status_o), 32'd1);
        rst_n = 1'b0; #1;
        chk("R1 reset mid drain", 32'(link_status_o), 32'd2);
        chk("R1 reset mid drain req bit", reg_rdata, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule